// File: doc/BRIEF.md
# Isochronous Cycle Loss Detector

This block watches one node of a serial bus link for isochronous cycles that pass without a cycle-start packet. It takes the low-order bit of the local cycle timer's count and makes its own cycle-synch event each time that bit changes. It then follows the bus strobes inside each cycle period: cycle-start packet seen, subaction gap, and arbitration reset gap. When a cycle is lost, it raises a one-clock lost-cycle pulse.

Loss is reported in one of two ways. In actual-only mode the pulse fires at the cycle boundary that closes a period in which no cycle-start packet appeared. In predictive mode the pulse can also fire early, inside the period, as soon as the gap sequence after the synch event shows that no cycle-start packet will come. Each period gives at most one pulse, whichever way it is reported. Both outputs are registered, so each output answers the input clock that caused it one clock later.

Top module: `iso_cycle_loss_mon`

## Requirements
- R1: `synch_pulse` is high for exactly one clock, one clock after a clock in which `cyc_lsb` differs from its value in the previous clock. The first clock after reset release only captures `cyc_lsb` and never produces a synch.
- R2: When a synch event closes a period that had no `start_seen` strobe after the previous synch event's clock, and no loss was reported in that period, `lost_pulse` is high in the same clock as `synch_pulse`.
- R3: With `predict_en` = 1, if the first `subgap_seen` after a synch event is followed by another `subgap_seen` or an `arbgap_seen` before any `start_seen`, `lost_pulse` rises one clock after that strobe.
- R4: With `predict_en` = 1, an `arbgap_seen` after a synch event, with no `start_seen` since that event, raises `lost_pulse` one clock later.
- R5: With `predict_en` = 0, the rules of R3 and R4 have no effect. `lost_pulse` is only ever high together with `synch_pulse`.
- R6: `lost_pulse` fires at most once per cycle period. A late `start_seen` after an early report produces no further pulse, and neither does the closing synch event.
- R7: A `start_seen` in the same clock as a synch event belongs to the new period, not the one being closed.
- R8: A `start_seen` that is the next strobe after the first subaction gap marks the period as good. Later gaps in that period report nothing. A `start_seen` in the same clock as a gap strobe takes precedence over it.
- R9: Reset clears all tracking, and both outputs are 0 during reset. No loss is reported before, or at, the first synch event after reset.
- R10: Gap strobes in the same clock as a synch event are not counted for the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_lsb | input | 1 | Low-order bit of the local cycle count |
| start_seen | input | 1 | Strobe: cycle-start packet sent or received |
| subgap_seen | input | 1 | Strobe: subaction gap detected |
| arbgap_seen | input | 1 | Strobe: arbitration reset gap detected |
| predict_en | input | 1 | 1 = predictive reporting, 0 = actual-only |
| synch_pulse | output | 1 | One-clock cycle-synch event |
| lost_pulse | output | 1 | One-clock lost-cycle indication |

## Verification
The period state is only visible through `lost_pulse`. A wrong phase or a stale start flag therefore appears either as a missing or extra pulse one clock after the next gap strobe, in predictive mode, or at the next synch pulse, in either mode. Each scenario therefore drives a chosen gap sequence and checks the output in the clock right after each strobe and at the closing boundary. A wrong reported-flag shows up as a second pulse, either at the boundary after an early report or after a late start. A wrong synch edge detector shows up as a missing or doubled `synch_pulse` in the clock after the toggle.

// File: rtl/iso_loss_pkg.sv
package iso_loss_pkg;

  // progress of one cycle period after its synch event
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,  // no synch seen since reset
    PH_WAIT    = 2'd1,  // synch seen, no start and no gap yet
    PH_GAP     = 2'd2,  // first subaction gap seen, awaiting next strobe
    PH_SETTLED = 2'd3   // period decided (start seen or loss predicted)
  } phase_t;

  typedef struct packed {
    logic start;
    logic subgap;
    logic arbgap;
  } bus_evt_t;

endpackage

// File: rtl/iso_synch_gen.sv
module iso_synch_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_lsb,
  output logic synch_now
);

  logic prev_lsb_q, prev_lsb_d;
  logic prev_vld_q, prev_vld_d;

  always_comb begin
    prev_lsb_d = cyc_lsb;
    prev_vld_d = 1'b1;
    synch_now  = prev_vld_q & (cyc_lsb ^ prev_lsb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lsb_q <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_lsb_q <= prev_lsb_d;
      prev_vld_q <= prev_vld_d;
    end
  end

endmodule

// File: rtl/iso_period_tracker.sv
module iso_period_tracker
  import iso_loss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     synch_now,
  input  bus_evt_t evt,
  input  logic     predict_en,
  output logic     lost_now
);

  phase_t phase_q, phase_d;
  logic   seen_q, seen_d;   // start strobe seen this period
  logic   rep_q, rep_d;     // loss already reported this period
  logic   actual, predict, pred_fire;

  always_comb begin
    phase_d = phase_q;
    seen_d  = seen_q;
    rep_d   = rep_q;
    actual  = 1'b0;
    predict = 1'b0;
    if (synch_now) begin
      // close the old period; start in this clock opens the new one
      actual  = (phase_q != PH_IDLE) && !seen_q && !rep_q;
      seen_d  = evt.start;
      rep_d   = 1'b0;
      phase_d = evt.start ? PH_SETTLED : PH_WAIT;
    end else begin
      case (phase_q)
        PH_WAIT: begin
          if (evt.start) begin
            seen_d  = 1'b1;
            phase_d = PH_SETTLED;
          end else if (evt.arbgap) begin
            predict = 1'b1;
            phase_d = PH_SETTLED;
          end else if (evt.subgap) begin
            phase_d = PH_GAP;
          end
        end
        PH_GAP: begin
          if (evt.start) begin
            seen_d  = 1'b1;
            phase_d = PH_SETTLED;
          end else if (evt.subgap || evt.arbgap) begin
            predict = 1'b1;
            phase_d = PH_SETTLED;
          end
        end
        PH_SETTLED: begin
          if (evt.start) seen_d = 1'b1;
        end
        default: ;
      endcase
    end
    pred_fire = predict && predict_en && !rep_q;
    if (pred_fire) rep_d = 1'b1;
    lost_now = actual || pred_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      seen_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      seen_q  <= seen_d;
      rep_q   <= rep_d;
    end
  end

endmodule

// File: rtl/iso_cycle_loss_mon.sv
module iso_cycle_loss_mon
  import iso_loss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_lsb,
  input  logic start_seen,
  input  logic subgap_seen,
  input  logic arbgap_seen,
  input  logic predict_en,
  output logic synch_pulse,
  output logic lost_pulse
);

  logic     synch_now;
  logic     lost_now;
  bus_evt_t evt;
  logic     synch_d, lost_d;
  logic     synch_q, lost_q;

  assign evt = '{start: start_seen, subgap: subgap_seen, arbgap: arbgap_seen};

  iso_synch_gen u_synch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_lsb   (cyc_lsb),
    .synch_now (synch_now)
  );

  iso_period_tracker u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .synch_now  (synch_now),
    .evt        (evt),
    .predict_en (predict_en),
    .lost_now   (lost_now)
  );

  always_comb begin
    synch_d = synch_now;
    lost_d  = lost_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synch_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      synch_q <= synch_d;
      lost_q  <= lost_d;
    end
  end

  assign synch_pulse = synch_q;
  assign lost_pulse  = lost_q;

endmodule

// File: rtl/iso_cycle_loss_chk.sv
module iso_cycle_loss_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_lsb,
  input logic predict_en,
  input logic synch_pulse,
  input logic lost_pulse
);

  logic [1:0] ck_cnt;
  logic       got_synch;
  logic       lost_in_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt         <= 2'd0;
      got_synch      <= 1'b0;
      lost_in_period <= 1'b0;
    end else begin
      if (ck_cnt != 2'd3) ck_cnt <= ck_cnt + 2'd1;
      if (synch_pulse) got_synch <= 1'b1;
      if (synch_pulse) lost_in_period <= 1'b0;
      else if (lost_pulse) lost_in_period <= 1'b1;
    end
  end

  // R1: synch follows an lsb change by one clock, and only then
  assert_synch_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt >= 2'd2) |-> (synch_pulse == ($past(cyc_lsb) != $past(cyc_lsb, 2))));

  // R5: without prediction, loss only at a boundary
  assert_actual_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt >= 2'd1 && !$past(predict_en) && lost_pulse) |-> synch_pulse);

  // R6: one report per period
  assert_once_per_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> !lost_in_period);

  // R9: nothing reported before or at the first synch
  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> got_synch);

endmodule

bind iso_cycle_loss_mon iso_cycle_loss_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_lsb     (cyc_lsb),
  .predict_en  (predict_en),
  .synch_pulse (synch_pulse),
  .lost_pulse  (lost_pulse)
);

// File: tb/sim_iso_cycle_loss_mon.sv
module sim_iso_cycle_loss_mon;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_lsb = 1'b0;
  logic start_seen = 1'b0;
  logic subgap_seen = 1'b0;
  logic arbgap_seen = 1'b0;
  logic predict_en = 1'b1;
  logic synch_pulse, lost_pulse;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  iso_cycle_loss_mon u0 (
    .clk(clk), .rst_n(rst_n), .cyc_lsb(cyc_lsb), .start_seen(start_seen),
    .subgap_seen(subgap_seen), .arbgap_seen(arbgap_seen),
    .predict_en(predict_en), .synch_pulse(synch_pulse), .lost_pulse(lost_pulse)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive strobes for one clock; outputs then reflect this clock
  task automatic step(input logic st, input logic sg, input logic ag);
    start_seen = st; subgap_seen = sg; arbgap_seen = ag;
    @(negedge clk);
    start_seen = 1'b0; subgap_seen = 1'b0; arbgap_seen = 1'b0;
  endtask

  task automatic sync(input logic st, input logic sg, input logic ag);
    cyc_lsb = ~cyc_lsb;
    step(st, sg, ag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 synch in reset", synch_pulse, 1'b0);
    chk("R9 lost in reset", lost_pulse, 1'b0);
    rst_n = 1'b1;
  endtask

  // closes any period and opens one already holding a start (R7)
  task automatic settle();
    sync(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_first();
    do_reset();
    step(0, 0, 0);
    chk("R1 no synch w/o toggle", synch_pulse, 1'b0);
    step(0, 0, 1);
    chk("R9 arbgap before first synch", lost_pulse, 1'b0);
    sync(0, 0, 0);
    chk("R1 synch after toggle", synch_pulse, 1'b1);
    chk("R9 no loss at first synch", lost_pulse, 1'b0);
    step(0, 0, 0);
    chk("R1 synch one clock only", synch_pulse, 1'b0);
  endtask

  task automatic t_actual();
    predict_en = 1'b0;
    step(0, 1, 0);
    step(0, 0, 0);
    sync(0, 0, 0);
    chk("R2 synch", synch_pulse, 1'b1);
    chk("R2 loss at boundary", lost_pulse, 1'b1);
    step(1, 0, 0);
    step(0, 0, 0);
    sync(0, 0, 0);
    chk("R2 no loss when start seen", lost_pulse, 1'b0);
    predict_en = 1'b1;
  endtask

  task automatic t_sub_sub();
    settle();
    sync(0, 0, 0);
    chk("R7 start in synch clock counted new", lost_pulse, 1'b0);
    step(0, 1, 0);
    chk("R3 first gap quiet", lost_pulse, 1'b0);
    step(0, 1, 0);
    chk("R3 second gap predicts", lost_pulse, 1'b1);
    step(1, 0, 0);
    chk("R6 late start quiet", lost_pulse, 1'b0);
    sync(0, 0, 0);
    chk("R6 boundary quiet after report", lost_pulse, 1'b0);
  endtask

  task automatic t_sub_arb();
    settle();
    sync(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    chk("R3 gap then arbgap predicts", lost_pulse, 1'b1);
    step(0, 0, 0);
    chk("R3 pulse one clock", lost_pulse, 1'b0);
  endtask

  task automatic t_arb();
    settle();
    sync(0, 0, 0);
    step(0, 0, 1);
    chk("R4 arbgap predicts", lost_pulse, 1'b1);
    step(0, 0, 1);
    chk("R6 second arbgap quiet", lost_pulse, 1'b0);
    sync(0, 0, 0);
    chk("R6 boundary quiet", lost_pulse, 1'b0);
  endtask

  task automatic t_good_seq();
    settle();
    sync(0, 0, 0);
    step(0, 1, 0);
    step(1, 0, 0);
    chk("R8 start after gap quiet", lost_pulse, 1'b0);
    step(0, 1, 0);
    step(0, 0, 1);
    chk("R8 later gaps quiet", lost_pulse, 1'b0);
    sync(0, 0, 0);
    chk("R8 boundary quiet", lost_pulse, 1'b0);
  endtask

  task automatic t_same_clock();
    settle();
    sync(0, 0, 0);
    step(1, 1, 0);
    chk("R8 start wins over gap", lost_pulse, 1'b0);
    step(0, 0, 1);
    chk("R8 arbgap after start quiet", lost_pulse, 1'b0);
  endtask

  task automatic t_no_predict();
    predict_en = 1'b0;
    settle();
    sync(0, 0, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R5 gaps ignored", lost_pulse, 1'b0);
    step(0, 0, 1);
    chk("R5 arbgap ignored", lost_pulse, 1'b0);
    sync(0, 0, 0);
    chk("R5 loss at boundary", lost_pulse, 1'b1);
    predict_en = 1'b1;
  endtask

  task automatic t_gap_in_synch();
    settle();
    sync(0, 0, 1);
    chk("R10 synch clock quiet", lost_pulse, 1'b0);
    step(0, 0, 0);
    chk("R10 arbgap in synch clock ignored", lost_pulse, 1'b0);
    step(0, 0, 1);
    chk("R10 later arbgap counts", lost_pulse, 1'b1);
  endtask

  task automatic t_reset_mid();
    settle();
    sync(0, 0, 0);
    do_reset();
    step(0, 0, 0);
    sync(0, 0, 0);
    chk("R9 synch after reset", synch_pulse, 1'b1);
    chk("R9 reset cleared period", lost_pulse, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_first();
    t_actual();
    t_sub_sub();
    t_sub_arb();
    t_arb();
    t_good_seq();
    t_same_clock();
    t_no_predict();
    t_gap_in_synch();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule